// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block turns data words into asynchronous serial frames on one output line. A frame is a low start bit, a data field of eight or nine bits sent least significant bit first, and one or two high stop bits. When parity is on, it takes the top position of the data field, so the field length does not change. Parity is computed over the lower field bits and is even or odd as configured. Each bit lasts sixteen ticks of an external oversampling strobe. An internal divide-by-sixteen counter sets the bit boundaries, and a frame can begin only on one of them.

A one-word holding register sits in front of the shift register. A word written while the shifter is free goes straight into it. A word written during a frame waits in the holding register and goes out right after the current frame, with no idle time between the two. Two single-cycle interrupt pulses are produced. One marks that the holding register has handed its word over, so the next word may be written. The other marks the start of the last stop bit. A write made while a word is already waiting replaces that word and sets a sticky overrun flag.

The format inputs are taken when a word enters the shift register. They are expected to stay stable from the write until the frame ends.

Top module: `serial_frame_tx`

## Requirements
- R1: Out of reset the line `txd` is 1, both interrupt pulses are 0 and `overrun` is 0.
- R2: `txd` changes only in the cycle after a clock edge on which the 16th, 32nd, 48th... `baud_tick` since reset was counted. A frame begins on such an overflow, and only when `run_en` is 1 and a word is loaded. Each bit lasts 16 ticks.
- R3: A frame is one 0 start bit, then the field bits LSB first, then stop bits at 1. The field is 9 bits when `fmt_nine`=1 and 8 bits otherwise. There are 2 stop bits when `two_stop`=1 and 1 otherwise.
- R4: When `par_en`=1, the top field bit (bit 8 for 9-bit fields, bit 7 for 8-bit fields) replaces the word bit there. It is the XOR of the field bits below it, XORed with `par_odd`. So `par_odd`=0 gives an even count of ones over the field.
- R5: A write while the shifter is free loads the shifter at once, and `buf_free_irq` is 1 in the cycle after the write.
- R6: A word written during a frame goes out right after that frame's last stop bit, with no gap. `buf_free_irq` pulses when it moves into the shifter.
- R7: `tx_done_irq` pulses in the cycle in which the last stop bit starts: the second stop bit with two stops, the only stop bit with one.
- R8: A write while a word is already held replaces that word, and the replaced word is never sent. It sets `overrun`, which stays 1 until reset.
- R9: With `run_en`=0 a loaded word does not start and the line stays 1. A frame already in progress when `run_en` falls is completed.
- R10: `buf_free_irq` and `tx_done_irq` are never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run_en | input | 1 | Allows new frames to start |
| baud_tick | input | 1 | Strobe at 16 times the bit rate |
| fmt_nine | input | 1 | 1: 9-bit field, 0: 8-bit field |
| par_en | input | 1 | Top field bit carries parity |
| par_odd | input | 1 | 1: odd parity, 0: even parity |
| two_stop | input | 1 | 1: two stop bits, 0: one |
| wr_en | input | 1 | Write strobe for `wr_word` |
| wr_word | input | 9 | Word to transmit |
| txd | output | 1 | Serial line |
| buf_free_irq | output | 1 | Pulse: word moved into shifter |
| tx_done_irq | output | 1 | Pulse: last stop bit begins |
| overrun | output | 1 | Sticky: held word was overwritten |

## Verification
The bench builds the block with its default oversampling ratio of 16 and drives `baud_tick` on every second clock, so one bit lasts 32 cycles. This is short enough to run every combination of field length, parity, parity sense and stop count over several back-to-back frames. Because the bench counts the ticks itself, it knows every overflow and can check each edge of the line against it. It also predicts the exact cycle of every completion pulse and of every chained start bit.

// File: rtl/sftx_pkg.sv
package sftx_pkg;

  localparam int unsigned FIELD_MAX = 9;
  localparam int unsigned CNT_W     = $clog2(FIELD_MAX + 1);

  typedef enum logic [1:0] {
    FS_IDLE  = 2'd0,
    FS_START = 2'd1,
    FS_DATA  = 2'd2,
    FS_STOP  = 2'd3
  } fs_state_e;

  // Number of field bits for the selected format.
  function automatic logic [CNT_W-1:0] field_len(input logic nine);
    return nine ? CNT_W'(FIELD_MAX) : CNT_W'(FIELD_MAX - 1);
  endfunction

  // Builds the field as it goes on the line: word bits, with the top
  // field position replaced by parity when parity is enabled.
  function automatic logic [FIELD_MAX-1:0] field_of(input logic [FIELD_MAX-1:0] w,
                                                     input logic nine,
                                                     input logic pen,
                                                     input logic podd);
    logic [FIELD_MAX-1:0] f;
    f = w;
    if (!nine) f[FIELD_MAX-1] = 1'b0;
    if (pen) begin
      if (nine) f[FIELD_MAX-1] = (^w[FIELD_MAX-2:0]) ^ podd;
      else      f[FIELD_MAX-2] = (^w[FIELD_MAX-3:0]) ^ podd;
    end
    return f;
  endfunction

endpackage

// File: rtl/sftx_prescaler.sv
module sftx_prescaler #(
  parameter int unsigned OVS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic baud_tick,
  output logic ovf
);
  localparam int unsigned CW = (OVS > 1) ? $clog2(OVS) : 1;
  localparam logic [CW-1:0] TOP = CW'(OVS - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (baud_tick) cnt <= (cnt == TOP) ? '0 : cnt + 1'b1;
  end

  assign ovf = baud_tick && (cnt == TOP);

  // R2: overflow cannot fire on two clocks in a row
  assert_ovf_spaced_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> !ovf);

  // R2: counter stays inside its range
  assert_cnt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= TOP);

endmodule

// File: rtl/sftx_holdbuf.sv
module sftx_holdbuf
  import sftx_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr,
  input  logic [FIELD_MAX-1:0] wr_data,
  input  logic                 take,
  output logic                 full,
  output logic [FIELD_MAX-1:0] data,
  output logic                 ovr
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      data <= '0;
      ovr  <= 1'b0;
    end else begin
      if (wr) begin
        data <= wr_data;
        full <= 1'b1;
        if (full && !take) ovr <= 1'b1;
      end else if (take) begin
        full <= 1'b0;
      end
    end
  end

  // R6: the shifter only takes a word that is present
  assert_take_needs_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> full);

  // R8: overwrite of a waiting word raises the flag
  assert_overwrite_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && full && !take) |=> ovr);

  // R8: flag is sticky
  assert_ovr_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ovr |=> ovr);

endmodule

// File: rtl/sftx_engine.sv
module sftx_engine
  import sftx_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ovf,
  input  logic                 run_en,
  input  logic                 cfg_nine,
  input  logic                 cfg_pen,
  input  logic                 cfg_podd,
  input  logic                 cfg_two,
  input  logic                 load_direct,
  input  logic [FIELD_MAX-1:0] direct_word,
  input  logic                 hold_full,
  input  logic [FIELD_MAX-1:0] hold_word,
  output logic                 take,
  output logic                 free_now,
  output logic                 sh_full,
  output logic                 txd,
  output logic                 bf_pulse,
  output logic                 done_pulse
);

  fs_state_e            state;
  logic [FIELD_MAX-1:0] shreg;
  logic [CNT_W-1:0]     bit_cnt;
  logic                 nine_q;
  logic                 two_q;
  logic                 stop2_q;
  logic                 txd_q;
  logic                 bf_q;
  logic                 done_q;

  // Named internal events
  logic end_frame;
  logic frame_go;
  logic last_data;

  assign end_frame = ovf && (state == FS_STOP) && (!two_q || stop2_q);
  assign frame_go  = ovf && (state == FS_IDLE) && sh_full && run_en;
  assign last_data = (bit_cnt == field_len(nine_q));
  assign take      = end_frame && hold_full;
  assign free_now  = !sh_full || (end_frame && !hold_full);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= FS_IDLE;
      shreg   <= '0;
      bit_cnt <= '0;
      nine_q  <= 1'b0;
      two_q   <= 1'b0;
      stop2_q <= 1'b0;
      sh_full <= 1'b0;
      txd_q   <= 1'b1;
      bf_q    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      bf_q   <= 1'b0;
      done_q <= 1'b0;
      case (state)
        FS_IDLE: begin
          if (frame_go) begin
            txd_q <= 1'b0;
            state <= FS_START;
          end
        end
        FS_START: begin
          if (ovf) begin
            txd_q   <= shreg[0];
            shreg   <= {1'b0, shreg[FIELD_MAX-1:1]};
            bit_cnt <= CNT_W'(1);
            state   <= FS_DATA;
          end
        end
        FS_DATA: begin
          if (ovf) begin
            if (last_data) begin
              txd_q   <= 1'b1;
              stop2_q <= 1'b0;
              state   <= FS_STOP;
              if (!two_q) done_q <= 1'b1;
            end else begin
              txd_q   <= shreg[0];
              shreg   <= {1'b0, shreg[FIELD_MAX-1:1]};
              bit_cnt <= bit_cnt + 1'b1;
            end
          end
        end
        FS_STOP: begin
          if (ovf) begin
            if (two_q && !stop2_q) begin
              stop2_q <= 1'b1;
              done_q  <= 1'b1;
            end else if (hold_full) begin
              shreg  <= field_of(hold_word, cfg_nine, cfg_pen, cfg_podd);
              nine_q <= cfg_nine;
              two_q  <= cfg_two;
              bf_q   <= 1'b1;
              if (run_en) begin
                txd_q <= 1'b0;
                state <= FS_START;
              end else begin
                state <= FS_IDLE;
              end
            end else begin
              sh_full <= 1'b0;
              state   <= FS_IDLE;
            end
          end
        end
        default: state <= FS_IDLE;
      endcase
      if (load_direct) begin
        shreg   <= field_of(direct_word, cfg_nine, cfg_pen, cfg_podd);
        nine_q  <= cfg_nine;
        two_q   <= cfg_two;
        sh_full <= 1'b1;
        bf_q    <= 1'b1;
      end
    end
  end

  assign txd        = txd_q;
  assign bf_pulse   = bf_q;
  assign done_pulse = done_q;

  // R1: an empty shifter means the line is idle
  assert_empty_is_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !sh_full |-> (state == FS_IDLE) && txd_q);

  // R2: the line only moves after an overflow
  assert_txd_on_ovf_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ovf) |-> $stable(txd_q));

  // R3: start slot is low, stop slots are high
  assert_start_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == FS_START) |-> !txd_q);
  assert_stop_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == FS_STOP) |-> txd_q);

  // R5: a direct load leaves a word in the shifter and signals buffer free
  assert_direct_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load_direct |=> sh_full && bf_q);

  // R6: a chained word starts on the very overflow that ends the frame
  assert_chain_no_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (take && run_en) |=> (state == FS_START) && !txd_q && bf_q);

  // R7: completion pulse marks the start of the final stop slot
  assert_done_in_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (state == FS_STOP) && txd_q);

  // R9: no frame leaves idle without run enable
  assert_hold_when_stopped_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == FS_IDLE) && !run_en) |=> (state == FS_IDLE));

  // R10: pulses last one cycle
  assert_bf_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bf_q |=> !bf_q);
  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

endmodule

// File: rtl/serial_frame_tx.sv
module serial_frame_tx
  import sftx_pkg::*;
#(
  parameter int unsigned OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run_en,
  input  logic       baud_tick,
  input  logic       fmt_nine,
  input  logic       par_en,
  input  logic       par_odd,
  input  logic       two_stop,
  input  logic       wr_en,
  input  logic [8:0] wr_word,
  output logic       txd,
  output logic       buf_free_irq,
  output logic       tx_done_irq,
  output logic       overrun
);

  logic                 ovf;
  logic                 take;
  logic                 free_now;
  logic                 sh_full;
  logic                 hold_full;
  logic [FIELD_MAX-1:0] hold_word;
  logic                 load_direct;
  logic                 hold_wr;

  assign load_direct = wr_en && free_now;
  assign hold_wr     = wr_en && !free_now;

  sftx_prescaler #(.OVS(OVS)) u_presc (
    .clk       (clk),
    .rst_n     (rst_n),
    .baud_tick (baud_tick),
    .ovf       (ovf)
  );

  sftx_holdbuf u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (hold_wr),
    .wr_data (wr_word),
    .take    (take),
    .full    (hold_full),
    .data    (hold_word),
    .ovr     (overrun)
  );

  sftx_engine u_eng (
    .clk         (clk),
    .rst_n       (rst_n),
    .ovf         (ovf),
    .run_en      (run_en),
    .cfg_nine    (fmt_nine),
    .cfg_pen     (par_en),
    .cfg_podd    (par_odd),
    .cfg_two     (two_stop),
    .load_direct (load_direct),
    .direct_word (wr_word),
    .hold_full   (hold_full),
    .hold_word   (hold_word),
    .take        (take),
    .free_now    (free_now),
    .sh_full     (sh_full),
    .txd         (txd),
    .bf_pulse    (buf_free_irq),
    .done_pulse  (tx_done_irq)
  );

  // R6: a waiting word always has an occupied shifter in front of it
  assert_hold_behind_shifter_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hold_full |-> sh_full);

  // R8: overrun cannot appear without a write
  assert_overrun_needs_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(wr_en));

endmodule

// File: tb/test_serial_frame_tx.sv
`timescale 1ns/1ps
module test_serial_frame_tx;
  localparam int OVS  = 16;
  localparam int TDIV = 2;
  localparam int BIT  = OVS * TDIV;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       run_en = 1'b0;
  logic       baud_tick = 1'b0;
  logic       fmt_nine = 1'b0;
  logic       par_en = 1'b0;
  logic       par_odd = 1'b0;
  logic       two_stop = 1'b0;
  logic       wr_en = 1'b0;
  logic [8:0] wr_word = '0;
  logic       txd;
  logic       buf_free_irq;
  logic       tx_done_irq;
  logic       overrun;

  serial_frame_tx #(.OVS(OVS)) i_serial_frame_tx (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .baud_tick(baud_tick),
    .fmt_nine(fmt_nine), .par_en(par_en), .par_odd(par_odd), .two_stop(two_stop),
    .wr_en(wr_en), .wr_word(wr_word), .txd(txd), .buf_free_irq(buf_free_irq),
    .tx_done_irq(tx_done_irq), .overrun(overrun)
  );

  always #2 clk = ~clk;

  int     n_chk = 0;
  int     n_fail = 0;
  bit     ended = 0;
  longint cyc = 0;
  int     ticks = 0;
  bit     tick_last = 0;
  int     align_err = 0;
  int     wid_err = 0;
  logic   txd_prev = 1'b1;
  logic   bf_prev = 1'b0;
  logic   dn_prev = 1'b0;
  longint done_cyc = -1;
  longint prev_end = -1;
  int     frames = 0;
  int     sent = 0;
  logic [8:0] q_word[$];
  bit         q_b2b[$];

  task automatic check(input bit ok, input string what, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // Expected field: counts ones with a loop rather than a reduction
  function automatic logic [8:0] model_field(input logic [8:0] w, input bit nine,
                                             input bit pe, input bit po);
    logic [8:0] f;
    int n;
    int ones;
    n = nine ? 9 : 8;
    f = w;
    ones = 0;
    if (!nine) f[8] = 1'b0;
    if (pe) begin
      for (int i = 0; i < n - 1; i++) ones += int'(w[i]);
      f[n-1] = ((ones % 2) == 1) ? !po : po;
    end
    return f;
  endfunction

  always @(posedge clk) begin
    cyc++;
    tick_last = rst_n && baud_tick;
    if (tick_last) ticks++;
  end

  initial begin
    int t;
    t = 0;
    forever begin
      @(negedge clk);
      baud_tick = (t == TDIV - 1);
      t = (t + 1) % TDIV;
    end
  end

  // R2 edge alignment, R10 pulse widths, R7 pulse time
  always @(negedge clk) begin
    if (rst_n) begin
      if (txd !== txd_prev && !(tick_last && (ticks % OVS) == 0)) align_err++;
      if (buf_free_irq && bf_prev) wid_err++;
      if (tx_done_irq && dn_prev) wid_err++;
      if (tx_done_irq) done_cyc = cyc;
    end
    txd_prev = txd;
    bf_prev  = buf_free_irq;
    dn_prev  = tx_done_irq;
  end

  // Line monitor: decodes every frame and compares with the expected queue
  initial begin
    longint     t0;
    int         n;
    int         s;
    logic [8:0] w;
    logic [8:0] ef;
    logic [8:0] got;
    bit         b2b;
    forever begin
      @(negedge clk);
      if (rst_n && txd === 1'b0) begin
        t0 = cyc;
        n  = fmt_nine ? 9 : 8;
        s  = two_stop ? 2 : 1;
        if (q_word.size() == 0) begin
          check(0, "R3 unexpected frame", 1, 0);
          w = '0;
          b2b = 0;
        end else begin
          w = q_word.pop_front();
          b2b = q_b2b.pop_front();
        end
        ef = model_field(w, fmt_nine, par_en, par_odd);
        if (b2b) check(t0 == prev_end, "R6 chained start time", t0, prev_end);
        repeat (BIT/2) @(negedge clk);
        check(txd === 1'b0, "R3 start bit", txd, 0);
        got = '0;
        for (int i = 0; i < n; i++) begin
          repeat (BIT) @(negedge clk);
          got[i] = txd;
        end
        if (par_en) check(got == ef, "R4 field with parity", got, ef);
        else        check(got == ef, "R3 data field", got, ef);
        for (int j = 0; j < s; j++) begin
          repeat (BIT) @(negedge clk);
          check(txd === 1'b1, "R3 stop bit", txd, 1);
        end
        check(done_cyc == t0 + longint'((n + s - 1 + 1) * BIT) - longint'(BIT) + longint'(BIT),
              "R7 done pulse cycle", done_cyc, t0 + longint'((n + s) * BIT));
        prev_end = t0 + longint'((1 + n + s) * BIT);
        frames++;
      end
    end
  end

  task automatic send(input logic [8:0] w, input bit direct);
    @(negedge clk);
    wr_en = 1'b1;
    wr_word = w;
    @(negedge clk);
    wr_en = 1'b0;
    if (direct) check(buf_free_irq === 1'b1, "R5 buffer free after direct load", buf_free_irq, 1);
  endtask

  task automatic push(input logic [8:0] w, input bit b2b);
    q_word.push_back(w);
    q_b2b.push_back(b2b);
    sent++;
  endtask

  task automatic wait_bf();
    do @(negedge clk); while (buf_free_irq !== 1'b1);
  endtask

  task automatic wait_drain();
    while (q_word.size() != 0) @(negedge clk);
    repeat (14 * BIT) @(negedge clk);
  endtask

  initial begin
    logic [8:0] w;
    int         nw;
    int         stay_low;
    void'($urandom(32'h1bad5eed));
    repeat (3) @(negedge clk);
    check(txd === 1'b1, "R1 reset line level", txd, 1);
    check(buf_free_irq === 1'b0, "R1 reset buffer pulse", buf_free_irq, 0);
    check(tx_done_irq === 1'b0, "R1 reset done pulse", tx_done_irq, 0);
    check(overrun === 1'b0, "R1 reset overrun", overrun, 0);
    rst_n = 1'b1;
    run_en = 1'b1;
    repeat (2 * BIT) @(negedge clk);
    check(txd === 1'b1 && frames == 0, "R1 idle with nothing written", txd, 1);

    // Every format combination, random words, chained frames
    for (int b = 0; b < 16; b++) begin
      fmt_nine = b[0];
      par_en   = b[1];
      par_odd  = b[2];
      two_stop = b[3];
      nw = 1 + int'($urandom_range(0, 3));
      w = 9'($urandom_range(0, 511));
      send(w, 1);
      push(w, 0);
      for (int k = 1; k < nw; k++) begin
        w = 9'($urandom_range(0, 511));
        send(w, 0);
        push(w, 1);
        wait_bf();
      end
      wait_drain();
    end

    // R9: stopped transmitter keeps a loaded word
    fmt_nine = 0; par_en = 0; par_odd = 0; two_stop = 0;
    run_en = 1'b0;
    send(9'h0A5, 1);
    push(9'h0A5, 0);
    stay_low = 0;
    for (int c = 0; c < 4 * BIT; c++) begin
      @(negedge clk);
      if (txd !== 1'b1) stay_low++;
    end
    check(stay_low == 0 && q_word.size() == 1, "R9 no start while disabled", stay_low, 0);
    run_en = 1'b1;
    wait_drain();

    // R9: disable during a frame; it completes and the held word waits
    send(9'h13C, 1);
    push(9'h13C, 0);
    send(9'h0C3, 0);
    push(9'h0C3, 0);
    while (q_word.size() != 1) @(negedge clk);
    run_en = 1'b0;
    repeat (14 * BIT) @(negedge clk);
    check(q_word.size() == 1 && txd === 1'b1, "R9 held word waits for enable", q_word.size(), 1);
    run_en = 1'b1;
    wait_drain();

    // R8: overwrite of a waiting word
    fmt_nine = 1; par_en = 0; two_stop = 1;
    send(9'h1F0, 1);
    push(9'h1F0, 0);
    send(9'h055, 0);
    check(overrun === 1'b0, "R8 single held word no overrun", overrun, 0);
    send(9'h1AA, 0);
    check(overrun === 1'b1, "R8 overwrite sets overrun", overrun, 1);
    push(9'h1AA, 1);
    wait_drain();
    check(overrun === 1'b1, "R8 overrun sticky", overrun, 1);

    check(frames == sent, "R3 frame count", frames, sent);
    check(align_err == 0, "R2 edges on overflow", align_err, 0);
    check(wid_err == 0, "R10 single-cycle pulses", wid_err, 0);
    finish_up();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_up();
  end

endmodule